// File: doc/BRIEF.md
# Single-Symbol Variable-Length Coefficient Decoder

This block decodes one variable-length codeword for a DCT coefficient per call. The codeword sits at the top of a 64-bit operand, starting at bit 63. A caller raises `call_valid` for one cycle with the window on `call_window`. After a fixed number of cycles, `LATENCY`, the block raises `res_valid` for one cycle and places a packed result word on `res_word`. The result holds the zero-run, the signed level, the number of bits the codeword used and an end-of-block flag. Because the delay does not depend on which codeword was decoded, software can schedule every call statically. Re-aligning the bitstream between calls and expanding runs into a coefficient block are left to the caller.

The code space is split into groups by the number of leading zeros in the window. Each group has its own small table, indexed by the few bits that follow the first '1'. This keeps the tables small: no single table covers the full 17-bit codeword range. A sign bit follows each table codeword. One group is an escape, which carries its run and level as raw fields. The input is a valid-only stream and has no ready signal. A call may be issued in any cycle, including back to back. The result side has no back-pressure: the consumer must take each result in the cycle `res_valid` is high.

Top module: `vlc_symbol_decoder`

## Requirements
- R1: While reset (`rst_n` low, synchronous) is held and until the first result, `res_valid` is 0 and `res_word` is all zeros.
- R2: Each cycle with `call_valid` high produces exactly one cycle with `res_valid` high, exactly `LATENCY` cycles later (default 3). Results come out in call order, and back-to-back calls are accepted.
- R3: A window that starts with '10' decodes to end-of-block, with length 2, run 0 and level 0.
- R4: A window that starts with '11' followed by a sign bit decodes to run 0, level magnitude 1 and length 3.
- R5: A window with k leading zeros (k = 1 to 4), then '1', then a 2-bit index i (most significant bit first), then a sign bit, decodes to run i, level magnitude k+1 and length k+4.
- R6: A window with k leading zeros (k = 6 to 11), then '1', then a 4-bit index i, then a sign bit, decodes to run i, level magnitude k and length k+6. The longest such codeword is 17 bits.
- R7: In the table groups of R4 to R6, a sign bit of 1 gives the negated level in 12-bit two's complement, and a sign bit of 0 gives the positive level.
- R8: A window that starts with '000001' is an escape. It is followed by a 6-bit run and then a 12-bit two's-complement level, both copied unchanged. The length is 24, and no sign bit is read.
- R9: A window with 12 or more leading zeros decodes to end-of-block with length 0, run 0 and level 0.
- R10: The `res_word` layout is: run in bits [5:0], level in bits [17:6], length in bits [22:18], end-of-block flag in bit 23, and bits [63:24] zero. Window bits after the codeword have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| call_valid | input | 1 | One-cycle call strobe |
| call_window | input | 64 | Bit window, codeword at the top starting at bit 63 |
| res_valid | output | 1 | Result strobe, `LATENCY` cycles after the call |
| res_word | output | 64 | Packed result word (run, level, length, end-of-block) |

## Verification
The assertions assume that the consumer takes every result in the cycle it appears, since there is no back-pressure. They also assume that `LATENCY` is at least 2, so that the call-history register in the checker lines up with the pipeline. The stimulus never stalls the output side. It builds every window from an explicit codeword followed by random tail bits, so each group, each sign and the escape boundary values are reached with known expected fields. Calls are issued both back to back and with gaps, so the fixed-latency rule is tested under dense and sparse traffic.

// File: rtl/vlcd_pkg.sv
package vlcd_pkg;
  localparam int WORD_W      = 64;
  localparam int RUN_W       = 6;
  localparam int LVL_W       = 12;
  localparam int LEN_W       = 5;
  localparam int PEEK_W      = 24;  // widest codeword (escape)
  localparam int MAX_LZ      = 12;  // zeros at or beyond this: no codeword
  localparam int ZCNT_W      = $clog2(MAX_LZ + 1);
  localparam int ESC_LZ      = 5;
  localparam int SHORT_IDX_W = 2;
  localparam int LONG_IDX_W  = 4;
  localparam int ESC_LEN     = ESC_LZ + 1 + RUN_W + LVL_W;
  localparam int EOB_LEN     = 2;

  typedef struct packed {
    logic             eob;
    logic [LEN_W-1:0] len;
    logic [LVL_W-1:0] level;
    logic [RUN_W-1:0] run;
  } sym_t;

  localparam int SYM_W = $bits(sym_t);

  function automatic logic [WORD_W-1:0] pack_sym(input sym_t s);
    return {{(WORD_W-SYM_W){1'b0}}, s};
  endfunction
endpackage

// File: rtl/vlc_lzc.sv
module vlc_lzc #(
  parameter int W  = 12,
  parameter int CW = 4
) (
  input  logic [W-1:0]  v,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (v[i]) cnt = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/vlc_group_rom.sv
module vlc_group_rom #(
  parameter int LZ    = 1,
  parameter int IDX_W = 2,
  parameter int MAG   = 2,
  parameter int RUN_W = 6,
  parameter int LVL_W = 12,
  parameter int LEN_W = 5
) (
  input  logic [IDX_W-1:0] idx,
  output logic [RUN_W-1:0] run,
  output logic [LVL_W-1:0] mag,
  output logic [LEN_W-1:0] len
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int CLEN  = LZ + 1 + IDX_W + 1;  // zeros, marker, index, sign

  logic [RUN_W+LVL_W-1:0] entry [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_fill
    assign entry[e] = {RUN_W'(e), LVL_W'(MAG)};
  end

  assign {run, mag} = entry[idx];
  assign len        = LEN_W'(CLEN);
endmodule

// File: rtl/vlc_delay_line.sv
module vlc_delay_line #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_v,
  input  logic [W-1:0] in_d,
  output logic         out_v,
  output logic [W-1:0] out_d
);
  if (DEPTH == 0) begin : g_pass
    assign out_v = in_v;
    assign out_d = in_d;
  end else begin : g_regs
    logic         v_q [DEPTH];
    logic [W-1:0] d_q [DEPTH];
    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v_q[s] <= 1'b0;
          d_q[s] <= '0;
        end else if (s == 0) begin
          v_q[s] <= in_v;
          d_q[s] <= in_v ? in_d : '0;
        end else begin
          v_q[s] <= v_q[s-1];
          d_q[s] <= d_q[s-1];
        end
      end
    end
    assign out_v = v_q[DEPTH-1];
    assign out_d = d_q[DEPTH-1];
  end
endmodule

// File: rtl/vlc_symbol_decoder.sv
module vlc_symbol_decoder
  import vlcd_pkg::*;
#(
  parameter int LATENCY = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_valid,
  input  logic [WORD_W-1:0] call_window,
  output logic              res_valid,
  output logic [WORD_W-1:0] res_word
);
  localparam int TAIL_DEPTH = LATENCY - 2;

  // stage 1: capture the top of the window
  logic              cap_v;
  logic [PEEK_W-1:0] cap_bits;
  logic              unused_low;
  assign unused_low = ^call_window[WORD_W-PEEK_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_v    <= 1'b0;
      cap_bits <= '0;
    end else begin
      cap_v <= call_valid;
      if (call_valid) cap_bits <= call_window[WORD_W-1 -: PEEK_W];
    end
  end

  // classification: leading zeros select the group
  logic [ZCNT_W-1:0] lz;
  logic [PEEK_W-1:0] after;
  logic              unused_after;

  vlc_lzc #(.W(MAX_LZ), .CW(ZCNT_W)) u_lzc (
    .v   (cap_bits[PEEK_W-1 -: MAX_LZ]),
    .cnt (lz)
  );

  assign after        = cap_bits << ({1'b0, lz} + 5'd1);
  assign unused_after = ^after[5:0];

  // per-group tables
  logic [RUN_W-1:0] g_run  [MAX_LZ];
  logic [LVL_W-1:0] g_mag  [MAX_LZ];
  logic [LEN_W-1:0] g_len  [MAX_LZ];
  logic             g_sign [MAX_LZ];

  for (genvar g = 0; g < MAX_LZ; g++) begin : g_grp
    if (g == 0) begin : g_lead_one
      assign g_run[g]  = '0;
      assign g_mag[g]  = LVL_W'(1);
      assign g_len[g]  = LEN_W'(3);
      assign g_sign[g] = after[PEEK_W-2];
    end else if (g == ESC_LZ) begin : g_escape_slot
      assign g_run[g]  = '0;
      assign g_mag[g]  = '0;
      assign g_len[g]  = '0;
      assign g_sign[g] = 1'b0;
    end else begin : g_table
      localparam int IW  = (g < ESC_LZ) ? SHORT_IDX_W : LONG_IDX_W;
      localparam int MAG = (g < ESC_LZ) ? g + 1 : g;
      vlc_group_rom #(
        .LZ(g), .IDX_W(IW), .MAG(MAG),
        .RUN_W(RUN_W), .LVL_W(LVL_W), .LEN_W(LEN_W)
      ) u_rom (
        .idx (after[PEEK_W-1 -: IW]),
        .run (g_run[g]),
        .mag (g_mag[g]),
        .len (g_len[g])
      );
      assign g_sign[g] = after[PEEK_W-1-IW];
    end
  end

  // stage 2: decode and register
  sym_t dec, dec_q;
  logic dec_v;

  always_comb begin
    dec = '0;
    if (lz >= ZCNT_W'(MAX_LZ)) begin
      dec.eob = 1'b1;
    end else if (lz == ZCNT_W'(0) && !after[PEEK_W-1]) begin
      dec.eob = 1'b1;
      dec.len = LEN_W'(EOB_LEN);
    end else if (lz == ZCNT_W'(ESC_LZ)) begin
      dec.run   = after[PEEK_W-1 -: RUN_W];
      dec.level = after[PEEK_W-1-RUN_W -: LVL_W];
      dec.len   = LEN_W'(ESC_LEN);
    end else begin
      dec.run   = g_run[lz];
      dec.level = g_sign[lz] ? (~g_mag[lz] + LVL_W'(1)) : g_mag[lz];
      dec.len   = g_len[lz];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_v <= 1'b0;
      dec_q <= '0;
    end else begin
      dec_v <= cap_v;
      dec_q <= cap_v ? dec : '0;
    end
  end

  // remaining cycles to reach the fixed latency
  logic             out_v;
  logic [SYM_W-1:0] out_d;

  vlc_delay_line #(.W(SYM_W), .DEPTH(TAIL_DEPTH)) u_tail (
    .clk   (clk),
    .rst_n (rst_n),
    .in_v  (dec_v),
    .in_d  (dec_q),
    .out_v (out_v),
    .out_d (out_d)
  );

  assign res_valid = out_v;
  assign res_word  = pack_sym(sym_t'(out_d));
endmodule

// File: rtl/vlc_symbol_decoder_chk.sv
module vlc_symbol_decoder_chk
  import vlcd_pkg::*;
#(
  parameter int LATENCY = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              call_valid,
  input logic              res_valid,
  input logic [WORD_W-1:0] res_word
);
  logic [LATENCY-1:0] hist;
  always_ff @(posedge clk) begin
    if (!rst_n) hist <= '0;
    else        hist <= {hist[LATENCY-2:0], call_valid};
  end

  logic             f_eob;
  logic [LEN_W-1:0] f_len;
  logic [LVL_W-1:0] f_lvl;
  logic [RUN_W-1:0] f_run;
  assign {f_eob, f_len, f_lvl, f_run} = res_word[SYM_W-1:0];

  // R2: result strobe follows the call strobe by exactly LATENCY cycles
  a_r2_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == hist[LATENCY-1]);

  // R10: bits above the packed fields stay zero
  a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_word[WORD_W-1:SYM_W] == '0);

  // R3 / R9: end-of-block carries no run or level
  a_r3_eob_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && f_eob) |-> (f_run == '0 && f_lvl == '0));

  // R9: end-of-block length is either 2 or 0
  a_r9_eob_len: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && f_eob) |-> (f_len == LEN_W'(EOB_LEN) || f_len == '0));

  // R6: table codewords are at most 17 bits and never have a zero level
  a_r6_table_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !f_eob && f_len != LEN_W'(ESC_LEN)) |-> (f_lvl != '0 && f_len <= LEN_W'(17)));
endmodule

bind vlc_symbol_decoder vlc_symbol_decoder_chk #(.LATENCY(LATENCY)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .call_valid (call_valid),
  .res_valid  (res_valid),
  .res_word   (res_word)
);

// File: tb/vlc_symbol_decoder_bench.sv
module vlc_symbol_decoder_bench;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        call_valid = 1'b0;
  logic [63:0] call_window = '0;
  logic        res_valid;
  logic [63:0] res_word;

  always #10 clk = ~clk;  // 50 MHz

  vlc_symbol_decoder #(.LATENCY(LAT)) u_vlc_symbol_decoder (
    .clk(clk), .rst_n(rst_n), .call_valid(call_valid), .call_window(call_window),
    .res_valid(res_valid), .res_word(res_word)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  logic [63:0] exp_q [$];
  int          due_q [$];
  string       tag_q [$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [63:0] mkexp(int run, int lvl, int len, bit eob);
    logic [11:0] l12;
    l12 = 12'(lvl);
    return {40'b0, eob, 5'(len), l12, 6'(run)};
  endfunction

  function automatic logic [63:0] mkwin(logic [63:0] code, int clen, logic [63:0] tail);
    return (code << (64 - clen)) | (tail >> clen);
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  task automatic call(input logic [63:0] win, input logic [63:0] exp, input string tag);
    @(negedge clk);
    call_valid  = 1'b1;
    call_window = win;
    exp_q.push_back(exp);
    due_q.push_back(cyc + LAT);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      call_valid  = 1'b0;
      call_window = rnd64();
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (res_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          failures++;
          $display("FAIL R2 unexpected result act=%h exp=none", res_word);
        end else begin
          logic [63:0] e;
          int d;
          string t;
          e = exp_q.pop_front();
          d = due_q.pop_front();
          t = tag_q.pop_front();
          if (res_word !== e || cyc != d) begin
            failures++;
            $display("FAIL %s act=%h@%0d exp=%h@%0d", t, res_word, cyc, e, d);
          end
        end
      end else if (due_q.size() > 0 && due_q[0] <= cyc) begin
        checks++;
        failures++;
        $display("FAIL R2 missing result act=none exp=%h@%0d", exp_q[0], due_q[0]);
        void'(exp_q.pop_front());
        void'(due_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL R2 watchdog act=hung exp=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: idle outputs during reset
    checks++;
    if (res_valid !== 1'b0 || res_word !== 64'h0) begin
      failures++;
      $display("FAIL R1 in reset act=%b/%h exp=0/0", res_valid, res_word);
    end
    rst_n = 1'b1;
    idle(2);
    checks++;
    if (res_valid !== 1'b0 || res_word !== 64'h0) begin
      failures++;
      $display("FAIL R1 after reset act=%b/%h exp=0/0", res_valid, res_word);
    end

    // R3: end-of-block, random tails
    for (int n = 0; n < 3; n++)
      call(mkwin(64'd2, 2, rnd64()), mkexp(0, 0, 2, 1'b1), "R3 eob");
    idle(1);

    // R4 / R7: lead-one group, both signs
    for (int s = 0; s < 2; s++)
      call(mkwin(64'(6 + s), 3, rnd64()), mkexp(0, s ? -1 : 1, 3, 1'b0), "R4 R7 lead-one");

    // R5 / R7: short groups, back to back
    for (int k = 1; k <= 4; k++)
      for (int i = 0; i < 4; i++)
        for (int s = 0; s < 2; s++)
          call(mkwin(64'((1 << 3) | (i << 1) | s), k + 4, rnd64()),
               mkexp(i, s ? -(k + 1) : (k + 1), k + 4, 1'b0), "R5 R7 short group");
    idle(5);

    // R6 / R7: long groups
    for (int k = 6; k <= 11; k++)
      for (int i = 0; i < 16; i++)
        for (int s = 0; s < 2; s++)
          call(mkwin(64'((1 << 5) | (i << 1) | s), k + 6, rnd64()),
               mkexp(i, s ? -k : k, k + 6, 1'b0), "R6 R7 long group");
    idle(2);

    // R8: escape boundaries
    begin
      int runs [5] = '{0, 63, 17, 1, 42};
      int lvls [5] = '{12'h800, 12'h7FF, 12'h001, 12'h000, 12'hFFF};
      for (int n = 0; n < 5; n++)
        call(mkwin(64'((1 << 18) | (runs[n] << 12) | lvls[n]), 24, rnd64()),
             mkexp(runs[n], lvls[n], 24, 1'b0), "R8 escape");
    end

    // R9: no codeword within the first 12 bits
    call(rnd64() >> 12, mkexp(0, 0, 0, 1'b1), "R9 twelve zeros");
    call(rnd64() >> 30, mkexp(0, 0, 0, 1'b1), "R9 many zeros");
    call(64'h0, mkexp(0, 0, 0, 1'b1), "R9 all zeros");

    // R10: tail bits ignored, sparse calls
    for (int n = 0; n < 4; n++) begin
      logic [63:0] tl;
      tl = (n == 0) ? 64'h0 : (n == 1) ? '1 : rnd64();
      call(mkwin(64'((1 << 3) | (2 << 1) | 1), 6, tl), mkexp(2, -3, 6, 1'b0), "R10 tail ignored");
      idle(n);
    end

    while (exp_q.size() > 0) idle(1);
    idle(LAT + 2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule